// File: doc/BRIEF.md
# Indexed Effective Address Generator

This unit turns an indexed operand specifier into the address a processor core should access. A request carries a mode code, a choice of base register and a 16-bit signed offset field. The current values of the four base registers and the two 8-bit accumulators sit on input ports. For direct modes the unit answers on the cycle after the request. It returns the effective address, an error flag and, for auto-update modes, a write-back of the changed base register.

The two indirect modes work in two steps. First the unit forms a pointer from the base plus either the 16-bit offset or the 16-bit double accumulator. It then reads the two bytes that make up the final address through a byte-wide read port that uses a valid/ready handshake. While that sequence runs the unit reports busy and takes no new requests. Instruction decoding and the register file live outside the block.

Top module: `idx_ea_gen`

## Requirements
- R1: Constant modes add the offset to the selected base, modulo 2^16: mode 0 uses a 5-bit offset, mode 1 a 9-bit offset and mode 2 the full 16 bits. Base codes are 0 = X, 1 = Y, 2 = SP and 3 = PC. `eaValid` is high for exactly the cycle after the accepted request, with `eaErr` and `wbEn` low.
- R2: A mode-0 offset outside -16..15, or a mode-1 offset outside -256..255, produces `eaValid` with `eaErr` high and `wbEn` low.
- R3: Mode 3 adds A, zero-extended, to the base. Mode 4 adds B, zero-extended. Mode 5 adds D = {A,B}, with A as the high byte. All sums wrap modulo 2^16.
- R4: The auto-update modes (6 and 7) are refused with `eaErr` and no write-back in two cases: the base is PC, or the step (the signed offset field) is not in 1..8 or -8..-1.
- R5: Mode 6 (pre-update) yields the address base+step and writes base+step back to the selected base. `wbEn` and `wbSel` are valid together with `eaValid`.
- R6: Mode 7 (post-update) yields the old base value as the address and writes base+step back to the selected base.
- R7: Mode 8 forms the pointer base+offset and mode 9 forms base+D. The unit first reads the byte at the pointer, then the byte at pointer+1, which wraps past 0xFFFF. `rdAddr` holds steady while `rdValid` waits for `rdReady`.
- R8: The first byte read becomes the high byte of the final address and the second byte the low byte. `eaValid` rises on the cycle after the second `rspValid`, with `eaErr` and `wbEn` low.
- R9: While `busy` is high, `reqValid` is ignored and `eaValid` stays low. `rspValid` is ignored unless a read response is awaited.
- R10: Mode codes 10 to 15 produce `eaValid` with `eaErr` high and `wbEn` low.
- R11: After reset, `busy`, `eaValid`, `wbEn` and `rdValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqMode | input | 4 | Addressing mode code |
| reqBase | input | 2 | Base select: 0 X, 1 Y, 2 SP, 3 PC |
| reqOffset | input | 16 | Signed offset or update step |
| regX | input | 16 | Index register X value |
| regY | input | 16 | Index register Y value |
| regSp | input | 16 | Stack pointer value |
| regPc | input | 16 | Program counter value |
| accA | input | 8 | Accumulator A |
| accB | input | 8 | Accumulator B |
| busy | output | 1 | Indirect sequence in progress |
| eaValid | output | 1 | Result strobe |
| eaAddr | output | 16 | Effective address |
| eaErr | output | 1 | Illegal mode, base or offset |
| wbEn | output | 1 | Base register write-back enable |
| wbSel | output | 2 | Base register to write |
| wbData | output | 16 | Updated base value |
| rdValid | output | 1 | Byte read request |
| rdAddr | output | 16 | Byte read address |
| rdReady | input | 1 | Read request accepted |
| rspValid | input | 1 | Read data valid |
| rspData | input | 8 | Read data byte |

## Verification
Some properties are checked on every cycle. A write-back never targets PC and never comes with an error. The read address holds while it waits for acceptance. The final indirect address appears, error-free, one cycle after the last byte arrives. No result is reported while busy. Only the directed scenarios can show the arithmetic itself: the values at the offset range limits, zero extension of A and B, 16-bit wrap, the pre-update versus post-update choice, byte order across the 0xFFFF wrap, and that a request made while busy is dropped.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  typedef enum logic [3:0] {
    MD_C5    = 4'd0,
    MD_C9    = 4'd1,
    MD_C16   = 4'd2,
    MD_ACCA  = 4'd3,
    MD_ACCB  = 4'd4,
    MD_ACCD  = 4'd5,
    MD_PRE   = 4'd6,
    MD_POST  = 4'd7,
    MD_IND16 = 4'd8,
    MD_INDD  = 4'd9
  } eaMode_e;

  typedef enum logic [1:0] {
    BS_X  = 2'd0,
    BS_Y  = 2'd1,
    BS_SP = 2'd2,
    BS_PC = 2'd3
  } baseSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_HI,
    ST_WAIT_HI,
    ST_REQ_LO,
    ST_WAIT_LO
  } seqState_e;

  typedef struct packed {
    logic loadDirect;
    logic loadPtr;
    logic capHi;
    logic finish;
    logic selLo;
  } eaCtrl_t;

endpackage

// File: rtl/idx_ea_ctl.sv
module idx_ea_ctl
  import idx_ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [3:0] reqMode,
  input  logic       rdReady,
  input  logic       rspValid,
  output eaCtrl_t    ctrl,
  output logic       busy,
  output logic       rdValid
);

  seqState_e state, nextState;
  logic      isIndirect;

  assign isIndirect = (reqMode == MD_IND16) || (reqMode == MD_INDD);

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (isIndirect) begin
            ctrl.loadPtr = 1'b1;
            nextState    = ST_REQ_HI;
          end else begin
            ctrl.loadDirect = 1'b1;
          end
        end
      end
      ST_REQ_HI:  if (rdReady) nextState = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (rspValid) begin
          ctrl.capHi = 1'b1;
          nextState  = ST_REQ_LO;
        end
      end
      ST_REQ_LO: begin
        ctrl.selLo = 1'b1;
        if (rdReady) nextState = ST_WAIT_LO;
      end
      ST_WAIT_LO: begin
        if (rspValid) begin
          ctrl.finish = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy    = (state != ST_IDLE);
  assign rdValid = (state == ST_REQ_HI) || (state == ST_REQ_LO);

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadDirect, ctrl.loadPtr, ctrl.capHi, ctrl.finish})); // R9

  AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capHi |=> (rdValid && ctrl.selLo)); // R7

endmodule

// File: rtl/idx_ea_dp.sv
module idx_ea_dp
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ACC_W       = 8,
  parameter int SHORT_OFF_W = 5,
  parameter int MID_OFF_W   = 9,
  parameter int STEP_MAX    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  eaCtrl_t              ctrl,
  input  logic [3:0]           reqMode,
  input  logic [1:0]           reqBase,
  input  logic [ADDR_W-1:0]    reqOffset,
  input  logic [ADDR_W-1:0]    regX,
  input  logic [ADDR_W-1:0]    regY,
  input  logic [ADDR_W-1:0]    regSp,
  input  logic [ADDR_W-1:0]    regPc,
  input  logic [ACC_W-1:0]     accA,
  input  logic [ACC_W-1:0]     accB,
  input  logic [ADDR_W/2-1:0]  rspData,
  output logic                 eaValid,
  output logic [ADDR_W-1:0]    eaAddr,
  output logic                 eaErr,
  output logic                 wbEn,
  output logic [1:0]           wbSel,
  output logic [ADDR_W-1:0]    wbData,
  output logic [ADDR_W-1:0]    rdAddr
);

  localparam int BYTE_W = ADDR_W / 2;
  localparam int PAD_W  = ADDR_W - ACC_W;
  localparam int D_W    = 2 * ACC_W;

  logic [ADDR_W-1:0]        baseVal, accAExt, accBExt, dVal, offSum;
  logic [D_W-1:0]           dRaw;
  logic signed [ADDR_W-1:0] offS;
  logic                     fitShort, fitMid, stepOk, isPc;
  logic [ADDR_W-1:0]        calcAddr, calcWbData;
  logic                     calcErr, calcWb;
  logic [ADDR_W-1:0]        ptrReg;
  logic [BYTE_W-1:0]        hiByte;

  assign dRaw = {accA, accB};
  generate
    if (D_W >= ADDR_W) begin : g_dTrim
      assign dVal = dRaw[ADDR_W-1:0];
    end else begin : g_dPad
      assign dVal = {{(ADDR_W-D_W){1'b0}}, dRaw};
    end
  endgenerate

  assign accAExt = {{PAD_W{1'b0}}, accA};
  assign accBExt = {{PAD_W{1'b0}}, accB};
  assign offS    = $signed(reqOffset);

  always_comb begin
    unique case (reqBase)
      BS_X:    baseVal = regX;
      BS_Y:    baseVal = regY;
      BS_SP:   baseVal = regSp;
      default: baseVal = regPc;
    endcase
  end

  assign isPc   = (reqBase == BS_PC);
  assign offSum = baseVal + reqOffset;

  assign fitShort = (reqOffset[ADDR_W-1:SHORT_OFF_W-1] == '0) ||
                    (reqOffset[ADDR_W-1:SHORT_OFF_W-1] == '1);
  assign fitMid   = (reqOffset[ADDR_W-1:MID_OFF_W-1] == '0) ||
                    (reqOffset[ADDR_W-1:MID_OFF_W-1] == '1);
  assign stepOk   = (offS != '0) && (int'(offS) <= STEP_MAX) &&
                    (int'(offS) >= -STEP_MAX);

  always_comb begin
    calcAddr   = offSum;
    calcWbData = offSum;
    calcErr    = 1'b0;
    calcWb     = 1'b0;
    case (reqMode)
      MD_C5:    calcErr = !fitShort;
      MD_C9:    calcErr = !fitMid;
      MD_C16,
      MD_IND16: calcAddr = offSum;
      MD_ACCA:  calcAddr = baseVal + accAExt;
      MD_ACCB:  calcAddr = baseVal + accBExt;
      MD_ACCD,
      MD_INDD:  calcAddr = baseVal + dVal;
      MD_PRE: begin
        calcErr = isPc || !stepOk;
        calcWb  = !calcErr;
      end
      MD_POST: begin
        calcAddr = baseVal;
        calcErr  = isPc || !stepOk;
        calcWb   = !calcErr;
      end
      default:  calcErr = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaValid <= 1'b0;
      eaAddr  <= '0;
      eaErr   <= 1'b0;
      wbEn    <= 1'b0;
      wbSel   <= '0;
      wbData  <= '0;
      ptrReg  <= '0;
      hiByte  <= '0;
    end else begin
      eaValid <= ctrl.loadDirect | ctrl.finish;
      wbEn    <= ctrl.loadDirect & calcWb;
      if (ctrl.loadDirect) begin
        eaAddr <= calcAddr;
        eaErr  <= calcErr;
        wbSel  <= reqBase;
        wbData <= calcWbData;
      end else if (ctrl.finish) begin
        eaAddr <= {hiByte, rspData};
        eaErr  <= 1'b0;
      end
      if (ctrl.loadPtr) ptrReg <= calcAddr;
      if (ctrl.capHi)   hiByte <= rspData;
    end
  end

  assign rdAddr = ctrl.selLo ? ptrReg + ADDR_W'(1) : ptrReg;

  AST_WB_NEVER_PC: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (wbSel != BS_PC)); // R4

  AST_ERR_BLOCKS_WB: assert property (@(posedge clk) disable iff (!rstN)
    eaErr && eaValid |-> !wbEn); // R2

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int ACC_W       = 8,
  parameter int SHORT_OFF_W = 5,
  parameter int MID_OFF_W   = 9,
  parameter int STEP_MAX    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [3:0]          reqMode,
  input  logic [1:0]          reqBase,
  input  logic [ADDR_W-1:0]   reqOffset,
  input  logic [ADDR_W-1:0]   regX,
  input  logic [ADDR_W-1:0]   regY,
  input  logic [ADDR_W-1:0]   regSp,
  input  logic [ADDR_W-1:0]   regPc,
  input  logic [ACC_W-1:0]    accA,
  input  logic [ACC_W-1:0]    accB,
  output logic                busy,
  output logic                eaValid,
  output logic [ADDR_W-1:0]   eaAddr,
  output logic                eaErr,
  output logic                wbEn,
  output logic [1:0]          wbSel,
  output logic [ADDR_W-1:0]   wbData,
  output logic                rdValid,
  output logic [ADDR_W-1:0]   rdAddr,
  input  logic                rdReady,
  input  logic                rspValid,
  input  logic [ADDR_W/2-1:0] rspData
);

  eaCtrl_t ctrl;

  idx_ea_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .rdReady  (rdReady),
    .rspValid (rspValid),
    .ctrl     (ctrl),
    .busy     (busy),
    .rdValid  (rdValid)
  );

  idx_ea_dp #(
    .ADDR_W      (ADDR_W),
    .ACC_W       (ACC_W),
    .SHORT_OFF_W (SHORT_OFF_W),
    .MID_OFF_W   (MID_OFF_W),
    .STEP_MAX    (STEP_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .reqMode   (reqMode),
    .reqBase   (reqBase),
    .reqOffset (reqOffset),
    .regX      (regX),
    .regY      (regY),
    .regSp     (regSp),
    .regPc     (regPc),
    .accA      (accA),
    .accB      (accB),
    .rspData   (rspData),
    .eaValid   (eaValid),
    .eaAddr    (eaAddr),
    .eaErr     (eaErr),
    .wbEn      (wbEn),
    .wbSel     (wbSel),
    .wbData    (wbData),
    .rdAddr    (rdAddr)
  );

  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdAddr)); // R7

  AST_FINAL_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.finish |=> eaValid && !eaErr && !wbEn); // R8

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !eaValid); // R9

endmodule

// File: tb/idx_ea_gen_tb.sv
module idx_ea_gen_tb;
  import idx_ea_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqMode = '0;
  logic [1:0]  reqBase = '0;
  logic [15:0] reqOffset = '0;
  logic [15:0] regX = 16'h1000, regY = 16'h2000, regSp = 16'h3FF0, regPc = 16'hFFF8;
  logic [7:0]  accA = 8'h84, accB = 8'hF0;
  logic        busy, eaValid, eaErr, wbEn, rdValid;
  logic [15:0] eaAddr, wbData, rdAddr;
  logic [1:0]  wbSel;
  logic        rdReady = 1'b0, rspValid = 1'b0;
  logic [7:0]  rspData = '0;

  int  nChecks = 0;
  int  nBad = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  idx_ea_gen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqBase(reqBase), .reqOffset(reqOffset), .regX(regX), .regY(regY),
    .regSp(regSp), .regPc(regPc), .accA(accA), .accB(accB), .busy(busy),
    .eaValid(eaValid), .eaAddr(eaAddr), .eaErr(eaErr), .wbEn(wbEn),
    .wbSel(wbSel), .wbData(wbData), .rdValid(rdValid), .rdAddr(rdAddr),
    .rdReady(rdReady), .rspValid(rspValid), .rspData(rspData)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memB(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic direct(input logic [3:0] m, input logic [1:0] b, input logic [15:0] off,
                        input logic [15:0] expA, input bit expErr, input bit expWb,
                        input logic [15:0] expWbD, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqBase = b; reqOffset = off;
    @(negedge clk);
    reqValid = 1'b0;
    chk(eaValid == 1'b1, tag, "eaValid", eaValid, 1);
    chk(eaErr == expErr, tag, "eaErr", eaErr, expErr);
    if (!expErr) chk(eaAddr == expA, tag, "eaAddr", eaAddr, expA);
    chk(wbEn == expWb, tag, "wbEn", wbEn, expWb);
    if (expWb) begin
      chk(wbSel == b, tag, "wbSel", wbSel, b);
      chk(wbData == expWbD, tag, "wbData", wbData, expWbD);
    end
    @(negedge clk);
    chk(eaValid == 1'b0, tag, "eaValid pulse", eaValid, 0);
  endtask

  task automatic serve(input logic [15:0] expAddr, input int delay, input bit junk);
    for (int i = 0; i < delay; i++) begin
      chk(rdValid && rdAddr == expAddr, "R7", "rdAddr held", rdAddr, expAddr);
      rspValid = junk; rspData = 8'hEE;
      @(negedge clk);
      rspValid = 1'b0;
    end
    chk(rdValid == 1'b1, "R7", "rdValid", rdValid, 1);
    chk(rdAddr == expAddr, "R7", "rdAddr", rdAddr, expAddr);
    rdReady = 1'b1;
    @(negedge clk);
    rdReady = 1'b0;
    chk(rdValid == 1'b0, "R7", "rdValid after accept", rdValid, 0);
    @(negedge clk);
    rspValid = 1'b1; rspData = memB(expAddr);
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic indirect(input logic [3:0] m, input logic [1:0] b, input logic [15:0] off,
                          input logic [15:0] ptr, input int delay, input bit probeBusy);
    logic [15:0] expW;
    expW = {memB(ptr), memB(ptr + 16'd1)};
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqBase = b; reqOffset = off;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R7", "busy", busy, 1);
    if (probeBusy) begin
      reqValid = 1'b1; reqMode = MD_C16; reqBase = BS_X; reqOffset = 16'h0001;
      @(negedge clk);
      reqValid = 1'b0;
      chk(eaValid == 1'b0, "R9", "request while busy", eaValid, 0);
    end
    serve(ptr, delay, probeBusy);
    chk(eaValid == 1'b0 && busy, "R9", "no result mid-sequence", eaValid, 0);
    serve(ptr + 16'd1, delay, 1'b0);
    chk(eaValid == 1'b1, "R8", "eaValid", eaValid, 1);
    chk(eaAddr == expW, "R8", "final address", eaAddr, expW);
    chk(!eaErr && !wbEn, "R8", "err/wb", {eaErr, wbEn}, 0);
    @(negedge clk);
    chk(eaValid == 1'b0 && busy == 1'b0, "R8", "idle after", {eaValid, busy}, 0);
  endtask

  task automatic testReset();
    chk(!busy && !eaValid && !wbEn && !rdValid, "R11", "reset outputs",
        {busy, eaValid, wbEn, rdValid}, 0);
  endtask

  task automatic testConst();
    direct(MD_C5,  BS_X,  16'hFFF0, 16'h0FF0, 0, 0, 0, "R1");
    direct(MD_C5,  BS_Y,  16'h000F, 16'h200F, 0, 0, 0, "R1");
    direct(MD_C9,  BS_SP, 16'hFF00, 16'h3EF0, 0, 0, 0, "R1");
    direct(MD_C9,  BS_PC, 16'h00FF, 16'h00F7, 0, 0, 0, "R1");
    direct(MD_C16, BS_X,  16'h7000, 16'h8000, 0, 0, 0, "R1");
    direct(MD_C16, BS_PC, 16'h0010, 16'h0008, 0, 0, 0, "R1");
  endtask

  task automatic testRange();
    direct(MD_C5, BS_X, 16'h0010, 0, 1, 0, 0, "R2");
    direct(MD_C5, BS_X, 16'hFFEF, 0, 1, 0, 0, "R2");
    direct(MD_C9, BS_Y, 16'h0100, 0, 1, 0, 0, "R2");
    direct(MD_C9, BS_Y, 16'hFEFF, 0, 1, 0, 0, "R2");
  endtask

  task automatic testAcc();
    direct(MD_ACCA, BS_X,  0, 16'h1084, 0, 0, 0, "R3");
    direct(MD_ACCB, BS_Y,  0, 16'h20F0, 0, 0, 0, "R3");
    direct(MD_ACCD, BS_SP, 0, 16'hC4E0, 0, 0, 0, "R3");
    direct(MD_ACCD, BS_PC, 0, 16'h84E8, 0, 0, 0, "R3");
  endtask

  task automatic testAuto();
    direct(MD_PRE,  BS_X,  16'h0002, 16'h1002, 0, 1, 16'h1002, "R5");
    direct(MD_PRE,  BS_SP, 16'hFFF8, 16'h3FE8, 0, 1, 16'h3FE8, "R5");
    direct(MD_POST, BS_Y,  16'h0008, 16'h2000, 0, 1, 16'h2008, "R6");
    direct(MD_POST, BS_X,  16'hFFFF, 16'h1000, 0, 1, 16'h0FFF, "R6");
    direct(MD_PRE,  BS_PC, 16'h0001, 0, 1, 0, 0, "R4");
    direct(MD_POST, BS_X,  16'h0000, 0, 1, 0, 0, "R4");
    direct(MD_PRE,  BS_Y,  16'h0009, 0, 1, 0, 0, "R4");
    direct(MD_POST, BS_SP, 16'hFFF7, 0, 1, 0, 0, "R4");
  endtask

  task automatic testIllegal();
    direct(4'd12, BS_X, 0, 0, 1, 0, 0, "R10");
    direct(4'd15, BS_SP, 16'h0001, 0, 1, 0, 0, "R10");
  endtask

  task automatic testIndirect();
    indirect(MD_IND16, BS_X,  16'h0010, 16'h1010, 0, 0);
    indirect(MD_INDD,  BS_PC, 16'h0000, 16'h84E8, 2, 0);
    indirect(MD_IND16, BS_Y,  16'hDFFF, 16'hFFFF, 1, 0);
  endtask

  task automatic testBusy();
    indirect(MD_IND16, BS_SP, 16'h0004, 16'h3FF4, 2, 1);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConst();
    testRange();
    testAcc();
    testAuto();
    testIllegal();
    testIndirect();
    testBusy();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule